// File: doc/BRIEF.md
# RF Sample Capture Bridge

This block takes a continuous stream of unsigned 10-bit codes from a parallel converter, in the converter's own clock domain. It turns each code into a 16-bit two's-complement word that spans the full signed range. The converted words cross into a second, faster, independent clock domain through a dual-clock FIFO. On that side they leave through a valid/ready stream that feeds a USB bridge. Gray-coded pointers cross each way through two-flop synchronizers.

A capture enable decides which codes are kept. Each rising edge of the enable starts a new capture. The write side then asks the read side to discard whatever is still unread, and it accepts no new codes until the read side confirms the flush. The read side drains at up to 60 M words/s, against a fill rate of at most 40 M codes/s, so the FIFO does not build up over a long session. A sticky overflow flag records any code refused because the FIFO was full. A sticky starvation flag records that the consumer was ready while nothing was available.

Top module: `rf_capture_bridge`

## Requirements
- R1: A code c is output as (c - 512) * 64 in 16-bit two's complement, which is the inverted top input bit followed by the low nine input bits and six zero bits: 0 gives 0x8000, 512 gives 0x0000, 1023 gives 0x7FC0.
- R2: The words leave in exactly the order in which codes were accepted, with no gap and no repeat, and their count equals the count of accepted codes.
- R3: A code is accepted at a write-clock edge when `cap_en` and `cap_active` are both high and the FIFO (2^AW entries) is not full. A code offered while the FIFO is full is discarded and `ovf_flag` rises after that edge. `ovf_flag` then stays high until reset, including across flushes.
- R4: `out_valid` is low while no word is stored. A word is consumed only at a read-clock edge where `out_valid` and `out_ready` are both high. While a word waits with `out_ready` low, `out_valid` and `out_data` hold.
- R5: While `cap_en` is low, no code is written, whatever `adc_code` does.
- R6: At a rising `cap_en`, `cap_active` drops for the flush handshake. Every word still unread is discarded, and only codes accepted after `cap_active` returns high are output.
- R7: `udf_flag` rises after a read-clock edge at which `out_ready` is high and `out_valid` is low, and it stays high until reset.
- R8: After reset, `out_valid`, `cap_active`, `ovf_flag` and `udf_flag` are all low.
- R9: With `out_ready` held high and a read clock 1.5 times the write clock, a long run of codes written on every write edge gets through with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | converter-side clock |
| wr_rst_n | input | 1 | active-low reset, write domain |
| cap_en | input | 1 | capture enable; rising edge starts a new capture |
| adc_code | input | IN_W | unsigned converter sample |
| cap_active | output | 1 | high when codes are being accepted |
| ovf_flag | output | 1 | sticky: a code was refused because the FIFO was full |
| rd_clk | input | 1 | consumer-side clock |
| rd_rst_n | input | 1 | active-low reset, read domain |
| out_data | output | OUT_W | converted signed sample |
| out_valid | output | 1 | `out_data` holds a stored word |
| out_ready | input | 1 | consumer takes the word at this edge |
| udf_flag | output | 1 | sticky: consumer was ready with nothing stored |

## Verification
The bench builds the block with AW = 3, an eight-entry FIFO, and keeps the 10-bit input and 16-bit output. The shallow FIFO means eight table codes fill it exactly and the ninth code hits the overflow path. The same small depth makes the sustained 600-sample ramp wrap the pointers dozens of times, so any slip in the Gray-code crossing at the 2:3 clock ratio would show up as loss or reordering. The flush handshake is exercised with three stale words sitting in the FIFO.

// File: rtl/rf_capture_bridge.sv
module rf_capture_bridge #(
  parameter int IN_W  = 10,
  parameter int OUT_W = 16,
  parameter int AW    = 10
) (
  input  logic             wr_clk,
  input  logic             wr_rst_n,
  input  logic             cap_en,
  input  logic [IN_W-1:0]  adc_code,
  output logic             cap_active,
  output logic             ovf_flag,
  input  logic             rd_clk,
  input  logic             rd_rst_n,
  output logic [OUT_W-1:0] out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             udf_flag
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int SH    = OUT_W - IN_W;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [OUT_W-1:0] mem [DEPTH];

  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2;
  logic          en_q, flushing, req_t, ack_s1, ack_s2;
  logic [PW-1:0] rbin, rgray, wg_s1, wg_s2;
  logic          req_s1, req_s2, ack_t;

  // write domain
  wire [PW-1:0]    wbin_nx = wbin + 1'b1;
  wire             full    = wgray == {~rg_s2[PW-1:PW-2], rg_s2[PW-3:0]};
  wire             wr_try  = cap_en & cap_active;
  wire             wr_go   = wr_try & ~full;
  wire [OUT_W-1:0] conv    = {~adc_code[IN_W-1], adc_code[IN_W-2:0], {SH{1'b0}}};

  assign cap_active = en_q & ~flushing;

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) begin
      wbin <= '0; wgray <= '0; rg_s1 <= '0; rg_s2 <= '0;
      en_q <= 1'b0; flushing <= 1'b0; req_t <= 1'b0;
      ack_s1 <= 1'b0; ack_s2 <= 1'b0; ovf_flag <= 1'b0;
    end else begin
      en_q  <= cap_en;
      rg_s1 <= rgray;  rg_s2  <= rg_s1;
      ack_s1 <= ack_t; ack_s2 <= ack_s1;
      if (cap_en && !en_q) begin
        flushing <= 1'b1;
        req_t    <= ~req_t;
      end else if (flushing && ack_s2 == req_t) begin
        flushing <= 1'b0;
      end
      if (wr_go) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
      if (wr_try && full) ovf_flag <= 1'b1;
    end

  always_ff @(posedge wr_clk)
    if (wr_go) mem[wbin[AW-1:0]] <= conv;

  AST_OVF_STICKY:  assert property (@(posedge wr_clk) disable iff (!wr_rst_n) ovf_flag |=> ovf_flag); // R3
  AST_FULL_HOLDS:  assert property (@(posedge wr_clk) disable iff (!wr_rst_n) (wr_try && full) |=> $stable(wbin)); // R3
  AST_IDLE_NOWR:   assert property (@(posedge wr_clk) disable iff (!wr_rst_n) !cap_en |=> $stable(wbin)); // R5
  AST_FLUSH_GATE:  assert property (@(posedge wr_clk) disable iff (!wr_rst_n) $rose(cap_en) |=> !cap_active); // R6

  // read domain
  wire [PW-1:0] rbin_nx  = rbin + 1'b1;
  wire [PW-1:0] wbin_s   = g2b(wg_s2);
  wire          flush_go = req_s2 != ack_t;
  wire          empty    = rgray == wg_s2;
  wire          pop      = out_valid & out_ready;

  assign out_valid = ~empty & ~flush_go;
  assign out_data  = mem[rbin[AW-1:0]];

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      rbin <= '0; rgray <= '0; wg_s1 <= '0; wg_s2 <= '0;
      req_s1 <= 1'b0; req_s2 <= 1'b0; ack_t <= 1'b0; udf_flag <= 1'b0;
    end else begin
      wg_s1  <= wgray; wg_s2  <= wg_s1;
      req_s1 <= req_t; req_s2 <= req_s1;
      if (flush_go) begin
        rbin  <= wbin_s;
        rgray <= wg_s2;
        ack_t <= req_s2;
      end else if (pop) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
      if (out_ready && !out_valid) udf_flag <= 1'b1;
    end

  AST_STALL_HOLD:  assert property (@(posedge rd_clk) disable iff (!rd_rst_n) (out_valid && !out_ready) |=> (flush_go || (out_valid && $stable(out_data)))); // R4
  AST_LEVEL_BOUND: assert property (@(posedge rd_clk) disable iff (!rd_rst_n) PW'(wbin_s - rbin) <= PW'(DEPTH)); // R3
  AST_UDF_STICKY:  assert property (@(posedge rd_clk) disable iff (!rd_rst_n) udf_flag |=> udf_flag); // R7
endmodule

// File: tb/sim_rf_capture_bridge.sv
module sim_rf_capture_bridge;
  logic        wr_clk = 0, rd_clk = 0;
  logic        wr_rst_n = 0, rd_rst_n = 0;
  logic        cap_en = 0, out_ready = 0;
  logic [9:0]  adc_code = '0;
  logic        cap_active, ovf_flag, out_valid, udf_flag;
  logic [15:0] out_data;

  int checks = 0, errors = 0;
  int bq [16];
  logic ovf_pre;

  always #3 wr_clk = ~wr_clk;
  always #2 rd_clk = ~rd_clk;

  rf_capture_bridge #(.IN_W(10), .OUT_W(16), .AW(3)) u0 (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .cap_en(cap_en), .adc_code(adc_code),
    .cap_active(cap_active), .ovf_flag(ovf_flag),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .udf_flag(udf_flag));

  localparam logic [25:0] TBL [8] = '{
    {10'd0,    16'h8000}, {10'd1,   16'h8040}, {10'd511, 16'hFFC0}, {10'd512, 16'h0000},
    {10'd513,  16'h0040}, {10'd1023,16'h7FC0}, {10'd256, 16'hC000}, {10'd768, 16'h4000}};

  function automatic logic [15:0] conv(input int c);
    int v;
    v = (c - 512) * 64;
    return v[15:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    cap_en = 0; out_ready = 0; wr_rst_n = 0; rd_rst_n = 0;
    repeat (4) @(negedge rd_clk);
    wr_rst_n = 1; rd_rst_n = 1;
    repeat (4) @(negedge rd_clk);
  endtask

  task automatic burst(input int n, input bit ramp);
    int t = 0;
    @(negedge wr_clk) cap_en = 1;
    while (!cap_active && t < 100) begin @(negedge wr_clk); t++; end
    for (int i = 0; i < n; i++) begin
      if (i == n - 1) ovf_pre = ovf_flag;
      adc_code = ramp ? 10'(i % 1024) : 10'(bq[i]);
      @(negedge wr_clk);
    end
    cap_en = 0;
  endtask

  task automatic pop(input logic [15:0] exp, input string req);
    int t = 0;
    @(negedge rd_clk) out_ready = 1;
    while (!out_valid && t < 100) begin @(negedge rd_clk); t++; end
    chk(out_valid && out_data == exp, req, out_data, exp);
    @(negedge rd_clk) out_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge rd_clk);
    errors++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R8 reset state
    chk(!out_valid && !cap_active && !ovf_flag && !udf_flag, "R8",
        {out_valid, cap_active, ovf_flag, udf_flag}, 0);

    // fill exactly, then one more (R3)
    for (int i = 0; i < 8; i++) bq[i] = int'(TBL[i][25:16]);
    bq[8] = 100;
    burst(9, 0);
    repeat (12) @(negedge rd_clk);
    chk(ovf_pre == 0, "R3 full without overflow", ovf_pre, 0);
    chk(ovf_flag == 1, "R3 overflow set", ovf_flag, 1);
    chk(out_valid && out_data == 16'h8000, "R4 head presented", out_data, 16'h8000);
    repeat (3) @(negedge rd_clk);
    chk(out_valid && out_data == 16'h8000, "R4 stall holds", out_data, 16'h8000);

    // R1 / R2 table walk
    for (int i = 0; i < 8; i++) pop(TBL[i][15:0], "R1 R2 table");
    repeat (10) @(negedge rd_clk);
    chk(!out_valid, "R3 refused code absent", out_valid, 0);
    chk(!udf_flag, "R7 no starvation yet", udf_flag, 0);
    @(negedge rd_clk) out_ready = 1;
    @(negedge rd_clk) out_ready = 0;
    chk(udf_flag, "R7 starvation flagged", udf_flag, 1);

    // R5 enable low
    for (int i = 0; i < 20; i++) begin @(negedge wr_clk) adc_code = 10'(i * 37); end
    repeat (10) @(negedge rd_clk);
    chk(!out_valid, "R5 idle writes nothing", out_valid, 0);

    // R6 flush on new capture
    bq[0] = 10; bq[1] = 11; bq[2] = 12;
    burst(3, 0);
    bq[0] = 5;
    burst(1, 0);
    repeat (12) @(negedge rd_clk);
    chk(out_valid && out_data == conv(5), "R6 stale words gone", out_data, conv(5));
    pop(conv(5), "R6 new word");
    repeat (10) @(negedge rd_clk);
    chk(!out_valid, "R6 nothing after flush", out_valid, 0);
    chk(ovf_flag, "R3 overflow persists", ovf_flag, 1);

    // reset again
    do_reset();
    chk(!ovf_flag && !udf_flag && !out_valid, "R8 R3 cleared by reset",
        {ovf_flag, udf_flag, out_valid}, 0);

    // R9 sustained ramp
    out_ready = 1;
    begin
      int got = 0, mism = 0, extra = 0;
      fork
        burst(600, 1);
        begin
          int t = 0;
          while (got < 600 && t < 10000) begin
            @(negedge rd_clk); t++;
            if (out_valid) begin
              if (out_data != conv(got % 1024)) mism++;
              got++;
            end
          end
        end
      join
      repeat (20) begin @(negedge rd_clk); if (out_valid) extra++; end
      chk(got == 600 && extra == 0, "R2 count", got + extra, 600);
      chk(mism == 0, "R2 R9 order", mism, 0);
      chk(!ovf_flag, "R9 no overflow", ovf_flag, 0);
    end
    out_ready = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule